// File: doc/BRIEF.md
# UART Register Front End

This block is the register-side face of a simple serial port. A host reaches it through a word-indexed bus with separate read and write strobes. Behind the bus it keeps two control words, a third control word, several plain storage words for baud and timing settings, two status words, a test word and a one-character receive holding register. On the line side it hands out each transmitted byte with a one-cycle valid pulse and takes in one character, or a break, at a time. It raises a registered interrupt when an enabled ready condition is present.

Serialisation, baud generation, deep buffering and modem control lie outside the block. The line side sees only whole characters. A character offered while the holding register is full is dropped, and `rx_ready` tells the sender when the register can take another.

Top module: `uart_regfront`

## Requirements
- R1: After power-on reset the words read as follows: index 0x25 reads 0x6040, 0x26 reads 0x4028, 0x2D reads 0x0060, 0x20 reads 0x0001, 0x21 reads 0x0005, 0x22 reads 0x0700, 0x2A reads 0, 0x2B reads 4, 0x24 and 0x2C read 0, and index 0x00 reads 0x4000. `irq` and `tx_valid` are low and `rx_ready` is high.
- R2: A character on `rx_char_valid` is taken only while `rx_ready` is high, and `rx_ready` is the inverse of index 0x25 bit 9. Taking it stores the byte zero-extended and sets 0x25 bit 9 and 0x26 bit 0. It also clears 0x2D bit 5. A character offered while the register is full changes nothing.
- R3: A `rx_break` taken through the same path stores 0x0800. When a break and a character are offered together, the break is stored.
- R4: A read of index 0x00 while 0x2D bit 5 is clear returns the stored word with bit 15 set. That read clears 0x25 bit 9 and 0x26 bit 0 and sets 0x2D bit 5. A read while bit 5 is set returns the stored word with bit 15 clear and alters nothing.
- R5: A write to index 0x10 while 0x21 bit 2 is set drives `tx_valid` high for exactly the next cycle, with `tx_byte` equal to bits 7:0 of the write data. During that cycle 0x25 bit 13 reads 0, and in the following cycle it reads 1 again.
- R6: A write to index 0x10 while 0x21 bit 2 is clear produces no `tx_valid` and leaves 0x25 unchanged.
- R7: One cycle after the state changes, `irq` equals (0x25 bit 13 AND 0x20 bit 13 AND 0x20 bit 6) OR (0x25 bit 9 AND 0x20 bit 9).
- R8: Writing ones to 0x25 clears only bits 15, 12, 11, 10, 8, 7, 5 and 4. Writing ones to 0x26 clears only bits 15, 13, 12, 11, 10, 8, 7, 6, 4, 2 and 1. Every other status bit keeps its value.
- R9: A write to 0x21 with bit 0 equal to 0 empties the receive register and sets it to 0x4000. It restores both status words, the test word, 0x20 (to 0), 0x22, 0x2A and 0x2B to their R1 values, and stores write data bits 15:0 with bit 0 forced to 1 in 0x21. Indices 0x24 and 0x2C keep their contents.
- R10: Writes to 0x20, 0x21, 0x22, 0x24, 0x2A and 0x2C keep only bits 15:0. A write to 0x29 sets the value read at 0x2B to bits 15:0 of the write data. Indices 0x23 and 0x29 always read 0.
- R11: Indices outside the map read 0 and ignore writes, and writes to 0x2D are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Active-low power-on reset |
| bus_rd | input | 1 | Read strobe; consumes the receive word at index 0x00 |
| bus_wr | input | 1 | Write strobe |
| bus_idx | input | 6 | Word index of the access |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data for `bus_idx`, valid in the same cycle |
| tx_byte | output | CW (8) | Byte being sent |
| tx_valid | output | 1 | One-cycle pulse marking `tx_byte` |
| rx_char_valid | input | 1 | A received character is offered |
| rx_char | input | CW (8) | Received character |
| rx_break | input | 1 | A received break is offered |
| rx_ready | output | 1 | Receive holding register is empty |
| irq | output | 1 | Registered interrupt request |

## Verification
The properties assume that the host never raises `bus_rd` and `bus_wr` in the same cycle and that `bus_idx` is driven to a defined value whenever either strobe is high. They place no limit on line-side offers, because an offer into a full register must simply be dropped. The bench issues exactly one bus operation per access task, changes inputs only on the falling clock edge, and returns every strobe to zero before the next access. It offers characters both into an empty and into a full holding register to exercise the drop path.

// File: rtl/uart_regfront_pkg.sv
package uart_regfront_pkg;
  localparam int REG_W = 16;
  localparam int IDX_W = 6;

  localparam logic [IDX_W-1:0] IX_RXD  = 6'h00;
  localparam logic [IDX_W-1:0] IX_TXD  = 6'h10;
  localparam logic [IDX_W-1:0] IX_CTL1 = 6'h20;
  localparam logic [IDX_W-1:0] IX_CTL2 = 6'h21;
  localparam logic [IDX_W-1:0] IX_CTL3 = 6'h22;
  localparam logic [IDX_W-1:0] IX_CTL4 = 6'h23;
  localparam logic [IDX_W-1:0] IX_FIFO = 6'h24;
  localparam logic [IDX_W-1:0] IX_STS1 = 6'h25;
  localparam logic [IDX_W-1:0] IX_STS2 = 6'h26;
  localparam logic [IDX_W-1:0] IX_BINC = 6'h29;
  localparam logic [IDX_W-1:0] IX_BMOD = 6'h2A;
  localparam logic [IDX_W-1:0] IX_BCNT = 6'h2B;
  localparam logic [IDX_W-1:0] IX_MSEC = 6'h2C;
  localparam logic [IDX_W-1:0] IX_TEST = 6'h2D;

  localparam int RXD_VALID = 15;
  localparam int S1_TRDY   = 13;
  localparam int S1_RRDY   = 9;
  localparam int S2_RDR    = 0;
  localparam int C1_TRDYEN = 13;
  localparam int C1_RRDYEN = 9;
  localparam int C1_TXEEN  = 6;
  localparam int C2_TXEN   = 2;
  localparam int C2_NRST   = 0;
  localparam int T_RXEMPTY = 5;

  localparam logic [REG_W-1:0] S1_W1C    = 16'h9DB0;
  localparam logic [REG_W-1:0] S2_W1C    = 16'hBDD6;
  localparam logic [REG_W-1:0] S1_RST    = 16'h4040;
  localparam logic [REG_W-1:0] S2_RST    = 16'h4028;
  localparam logic [REG_W-1:0] TEST_BASE = 16'h0040;
  localparam logic [REG_W-1:0] CTL3_RST  = 16'h0700;
  localparam logic [REG_W-1:0] BCNT_RST  = 16'h0004;
  localparam logic [REG_W-1:0] CTL1_BOOT = 16'h0001;
  localparam logic [REG_W-1:0] CTL2_BOOT = 16'h0005;
  localparam logic [REG_W-1:0] RXD_RST   = 16'h4000;
  localparam logic [REG_W-1:0] RXD_BRKW  = 16'h0800;

  function automatic logic irq_eval(input logic [REG_W-1:0] sts1,
                                    input logic [REG_W-1:0] ctl1);
    return (sts1[S1_TRDY] & ctl1[C1_TRDYEN] & ctl1[C1_TXEEN]) |
           (sts1[S1_RRDY] & ctl1[C1_RRDYEN]);
  endfunction

  function automatic logic [REG_W-1:0] w1c(input logic [REG_W-1:0] cur,
                                           input logic [REG_W-1:0] wd,
                                           input logic [REG_W-1:0] mask);
    return cur & ~(wd & mask);
  endfunction
endpackage

// File: rtl/uart_rxhold.sv
module uart_rxhold
  import uart_regfront_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic             consume,
  input  logic             ch_valid,
  input  logic             ch_brk,
  input  logic [CW-1:0]    ch_data,
  output logic             accept,
  output logic             full,
  output logic [REG_W-1:0] hold_q
);
  assign accept = (ch_valid | ch_brk) & ~full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full   <= 1'b0;
      hold_q <= RXD_RST;
    end else if (soft_clr) begin
      full   <= 1'b0;
      hold_q <= RXD_RST;
    end else if (accept) begin
      full   <= 1'b1;
      hold_q <= ch_brk ? RXD_BRKW : REG_W'(ch_data);
    end else if (consume) begin
      full   <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_txstrobe.sv
module uart_txstrobe #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_clr,
  input  logic          go,
  input  logic [CW-1:0] data,
  output logic          tx_valid_q,
  output logic [CW-1:0] tx_byte_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid_q <= 1'b0;
      tx_byte_q  <= '0;
    end else begin
      tx_valid_q <= go & ~soft_clr;
      if (go) tx_byte_q <= data;
    end
  end
endmodule

// File: rtl/uart_irqgen.sv
module uart_irqgen
  import uart_regfront_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] sts1,
  input  logic [REG_W-1:0] ctl1,
  output logic             irq_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_eval(sts1, ctl1);
  end
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_regfront_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [IDX_W-1:0] bus_idx,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic [CW-1:0]    tx_byte,
  output logic             tx_valid,
  input  logic             rx_char_valid,
  input  logic [CW-1:0]    rx_char,
  input  logic             rx_break,
  output logic             rx_ready,
  output logic             irq
);
  logic [REG_W-1:0] ctl1_q, ctl2_q, ctl3_q, fifo_q, bmod_q, bcnt_q, msec_q;
  logic [REG_W-1:0] s1_q, s2_q;
  logic [REG_W-1:0] sts1, sts2, test_w, hold_q, wd16, rv;
  logic             rx_full, rx_accept, rx_consume, soft_rst, tx_go;

  assign wd16       = bus_wdata[REG_W-1:0];
  assign soft_rst   = bus_wr && bus_idx == IX_CTL2 && !bus_wdata[C2_NRST];
  assign tx_go      = bus_wr && bus_idx == IX_TXD && ctl2_q[C2_TXEN];
  assign rx_consume = bus_rd && bus_idx == IX_RXD && rx_full;

  uart_rxhold #(.CW(CW)) u_rx (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_rst), .consume(rx_consume),
    .ch_valid(rx_char_valid), .ch_brk(rx_break), .ch_data(rx_char),
    .accept(rx_accept), .full(rx_full), .hold_q(hold_q)
  );

  uart_txstrobe #(.CW(CW)) u_tx (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_rst), .go(tx_go),
    .data(bus_wdata[CW-1:0]), .tx_valid_q(tx_valid), .tx_byte_q(tx_byte)
  );

  uart_irqgen u_irq (
    .clk(clk), .rst_n(rst_n), .sts1(sts1), .ctl1(ctl1_q), .irq_q(irq)
  );

  always_comb begin
    sts1 = s1_q;
    sts1[S1_RRDY] = rx_full;
    sts1[S1_TRDY] = ~tx_valid;
    sts2 = s2_q;
    sts2[S2_RDR] = rx_full;
    test_w = TEST_BASE;
    test_w[T_RXEMPTY] = ~rx_full;
  end

  assign rx_ready = ~rx_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl1_q <= CTL1_BOOT;
      ctl2_q <= CTL2_BOOT;
      ctl3_q <= CTL3_RST;
      fifo_q <= '0;
      bmod_q <= '0;
      bcnt_q <= BCNT_RST;
      msec_q <= '0;
      s1_q   <= S1_RST;
      s2_q   <= S2_RST;
    end else if (soft_rst) begin
      ctl1_q <= '0;
      ctl2_q <= wd16 | REG_W'(1);
      ctl3_q <= CTL3_RST;
      bmod_q <= '0;
      bcnt_q <= BCNT_RST;
      s1_q   <= S1_RST;
      s2_q   <= S2_RST;
    end else if (bus_wr) begin
      case (bus_idx)
        IX_CTL1: ctl1_q <= wd16;
        IX_CTL2: ctl2_q <= wd16;
        IX_CTL3: ctl3_q <= wd16;
        IX_FIFO: fifo_q <= wd16;
        IX_STS1: s1_q   <= w1c(s1_q, wd16, S1_W1C);
        IX_STS2: s2_q   <= w1c(s2_q, wd16, S2_W1C);
        IX_BINC: bcnt_q <= wd16;
        IX_BMOD: bmod_q <= wd16;
        IX_MSEC: msec_q <= wd16;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (bus_idx)
      IX_RXD: begin
        rv = hold_q;
        rv[RXD_VALID] = rx_full;
      end
      IX_CTL1: rv = ctl1_q;
      IX_CTL2: rv = ctl2_q;
      IX_CTL3: rv = ctl3_q;
      IX_FIFO: rv = fifo_q;
      IX_STS1: rv = sts1;
      IX_STS2: rv = sts2;
      IX_BMOD: rv = bmod_q;
      IX_BCNT: rv = bcnt_q;
      IX_MSEC: rv = msec_q;
      IX_TEST: rv = test_w;
      default: rv = '0;
    endcase
  end

  assign bus_rdata = DW'(rv);
endmodule

// File: rtl/uart_regfront_chk.sv
module uart_regfront_chk
  import uart_regfront_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_rd,
  input logic             bus_wr,
  input logic [IDX_W-1:0] bus_idx,
  input logic [DW-1:0]    bus_wdata,
  input logic             tx_valid,
  input logic [CW-1:0]    tx_byte,
  input logic             rx_char_valid,
  input logic             rx_break,
  input logic             rx_ready,
  input logic             irq,
  input logic [REG_W-1:0] ctl1_q,
  input logic [REG_W-1:0] ctl2_q,
  input logic             soft_rst
);
  assert_tx_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_idx == IX_TXD && ctl2_q[C2_TXEN])
      |=> (tx_valid && tx_byte == $past(bus_wdata[CW-1:0])));

  assert_tx_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_idx == IX_TXD && !ctl2_q[C2_TXEN]) |=> !tx_valid);

  assert_rx_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && (rx_char_valid || rx_break) && !soft_rst) |=> !rx_ready);

  assert_rx_drain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_ready && bus_rd && bus_idx == IX_RXD) |=> rx_ready);

  assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl1_q[C1_RRDYEN] && !ctl1_q[C1_TXEEN]) |=> !irq);

  assert_soft_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (ctl2_q[C2_NRST] && ctl1_q == '0 && rx_ready && !tx_valid));
endmodule

bind uart_regfront uart_regfront_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_idx(bus_idx), .bus_wdata(bus_wdata), .tx_valid(tx_valid),
  .tx_byte(tx_byte), .rx_char_valid(rx_char_valid), .rx_break(rx_break),
  .rx_ready(rx_ready), .irq(irq), .ctl1_q(ctl1_q), .ctl2_q(ctl2_q),
  .soft_rst(soft_rst)
);

// File: tb/sim_uart_regfront.sv
module sim_uart_regfront;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_idx = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  tx_byte;
  logic        tx_valid;
  logic        rx_char_valid = 1'b0, rx_break = 1'b0;
  logic [7:0]  rx_char = '0;
  logic        rx_ready, irq;

  int n_run = 0, n_fail = 0;
  logic [31:0] v;

  uart_regfront u0 (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_byte(tx_byte), .tx_valid(tx_valid), .rx_char_valid(rx_char_valid),
    .rx_char(rx_char), .rx_break(rx_break), .rx_ready(rx_ready), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [5:0] idx, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_idx = idx; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [5:0] idx, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_idx = idx; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic peek(input logic [5:0] idx, output logic [31:0] d);
    bus_idx = idx; #1 d = bus_rdata;
  endtask

  task automatic push(input logic [7:0] c, input logic brk);
    @(negedge clk); rx_char_valid = ~brk; rx_break = brk; rx_char = c;
    @(negedge clk); rx_char_valid = 1'b0; rx_break = 1'b0;
  endtask

  function automatic bit mapped(input int i);
    return i == 0 || i == 'h10 || (i >= 'h20 && i <= 'h26) || (i >= 'h29 && i <= 'h2D);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 power-on values
    peek(6'h25, v); check("R1 sts1", v, 32'h6040);
    peek(6'h26, v); check("R1 sts2", v, 32'h4028);
    peek(6'h2D, v); check("R1 test", v, 32'h0060);
    peek(6'h20, v); check("R1 ctl1", v, 32'h0001);
    peek(6'h21, v); check("R1 ctl2", v, 32'h0005);
    peek(6'h22, v); check("R1 ctl3", v, 32'h0700);
    peek(6'h2A, v); check("R1 bmod", v, 32'h0);
    peek(6'h2B, v); check("R1 bcnt", v, 32'h4);
    peek(6'h24, v); check("R1 fifo", v, 32'h0);
    peek(6'h2C, v); check("R1 msec", v, 32'h0);
    peek(6'h00, v); check("R1 rxd", v, 32'h4000);
    check("R1 pins", {irq, tx_valid, rx_ready}, 32'b001);

    // R4 read while empty has no effect
    do_rd(6'h00, v); check("R4 empty read", v, 32'h4000);
    peek(6'h2D, v); check("R4 empty keeps test", v, 32'h0060);

    // R2/R4 sweep of every character value
    for (int c = 0; c < 256; c++) begin
      push(8'(c), 1'b0);
      peek(6'h25, v); check("R2 sts1 full", v, 32'h6240);
      peek(6'h26, v); check("R2 sts2 full", v, 32'h4029);
      peek(6'h2D, v); check("R2 test full", v, 32'h0040);
      check("R2 rx_ready", {31'b0, rx_ready}, 32'h0);
      push(8'(c) ^ 8'hFF, 1'b0);
      do_rd(6'h00, v); check("R4 full read", v, 32'h8000 | 32'(c));
      peek(6'h25, v); check("R4 sts1 drained", v, 32'h6040);
      peek(6'h2D, v); check("R4 test drained", v, 32'h0060);
    end

    // R3 break, alone and together with a character
    push(8'h00, 1'b1);
    do_rd(6'h00, v); check("R3 break word", v, 32'h8800);
    @(negedge clk); rx_char_valid = 1'b1; rx_break = 1'b1; rx_char = 8'h5A;
    @(negedge clk); rx_char_valid = 1'b0; rx_break = 1'b0;
    do_rd(6'h00, v); check("R3 break wins", v, 32'h8800);

    // R7 interrupt over all enable and receive-full combinations
    for (int k = 0; k < 16; k++) begin
      bit want_full;
      want_full = k[3];
      if (want_full && rx_ready) push(8'h33, 1'b0);
      if (!want_full && !rx_ready) do_rd(6'h00, v);
      do_wr(6'h20, (32'(k[2]) << 13) | (32'(k[1]) << 9) | (32'(k[0]) << 6) | 32'h1);
      @(negedge clk);
      check("R7 irq combo", {31'b0, irq},
            {31'b0, (k[2] & k[0]) | (k[1] & want_full)});
    end
    if (!rx_ready) do_rd(6'h00, v);

    // R5 transmit pulses with irq dip
    do_wr(6'h20, 32'h2041);
    @(negedge clk);
    check("R5 irq before tx", {31'b0, irq}, 32'h1);
    for (int b = 0; b < 4; b++) begin
      do_wr(6'h10, 32'hFFFF_FF00 | 32'(8'hA5 + b * 17));
      check("R5 tx_valid", {31'b0, tx_valid}, 32'h1);
      check("R5 tx_byte", {24'b0, tx_byte}, 32'(8'(8'hA5 + b * 17)));
      peek(6'h25, v); check("R5 trdy low", v, 32'h4040);
      @(negedge clk);
      check("R5 tx_valid end", {31'b0, tx_valid}, 32'h0);
      check("R5 irq dip", {31'b0, irq}, 32'h0);
      peek(6'h25, v); check("R5 trdy back", v, 32'h6040);
      @(negedge clk);
      check("R5 irq back", {31'b0, irq}, 32'h1);
    end

    // R6 transmit gated off
    do_wr(6'h21, 32'h0001);
    do_wr(6'h10, 32'h0000_0077);
    check("R6 no tx_valid", {31'b0, tx_valid}, 32'h0);
    peek(6'h25, v); check("R6 sts1 unchanged", v, 32'h6040);
    do_wr(6'h21, 32'h0005);

    // R8 write-one-to-clear masks leave fixed bits alone
    for (int b = 0; b < 16; b++) begin
      do_wr(6'h25, 32'(1) << b);
      peek(6'h25, v); check("R8 sts1 bit", v, 32'h6040);
      do_wr(6'h26, 32'(1) << b);
      peek(6'h26, v); check("R8 sts2 bit", v, 32'h4028);
    end

    // R10 sixteen-bit storage and aliasing
    do_wr(6'h22, 32'hABCD_1234); peek(6'h22, v); check("R10 ctl3", v, 32'h1234);
    do_wr(6'h24, 32'h1111_0033); peek(6'h24, v); check("R10 fifo", v, 32'h0033);
    do_wr(6'h2A, 32'hF0F0_5A5A); peek(6'h2A, v); check("R10 bmod", v, 32'h5A5A);
    do_wr(6'h2C, 32'h0001_03E8); peek(6'h2C, v); check("R10 msec", v, 32'h03E8);
    do_wr(6'h20, 32'hFFFF_0000); peek(6'h20, v); check("R10 ctl1", v, 32'h0000);
    do_wr(6'h29, 32'h0001_2345); peek(6'h2B, v); check("R10 binc to bcnt", v, 32'h2345);
    peek(6'h29, v); check("R10 binc reads zero", v, 32'h0);
    do_wr(6'h23, 32'hFFFF_FFFF); peek(6'h23, v); check("R10 ctl4 zero", v, 32'h0);

    // R11 unmapped indices and test word writes
    for (int i = 0; i < 64; i++) begin
      if (!mapped(i)) begin
        do_wr(6'(i), 32'hFFFF_FFFF);
        peek(6'(i), v); check("R11 unmapped", v, 32'h0);
      end
    end
    do_wr(6'h2D, 32'h0);
    peek(6'h2D, v); check("R11 test ignores write", v, 32'h0060);

    // R9 soft reset with a character held
    push(8'h41, 1'b0);
    do_wr(6'h21, 32'hFFFF_0006);
    peek(6'h21, v); check("R9 ctl2 forced", v, 32'h0007);
    peek(6'h20, v); check("R9 ctl1", v, 32'h0);
    peek(6'h22, v); check("R9 ctl3", v, 32'h0700);
    peek(6'h2A, v); check("R9 bmod", v, 32'h0);
    peek(6'h2B, v); check("R9 bcnt", v, 32'h4);
    peek(6'h00, v); check("R9 rxd", v, 32'h4000);
    peek(6'h25, v); check("R9 sts1", v, 32'h6040);
    peek(6'h2D, v); check("R9 test", v, 32'h0060);
    peek(6'h24, v); check("R9 fifo kept", v, 32'h0033);
    peek(6'h2C, v); check("R9 msec kept", v, 32'h03E8);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule